// File: doc/BRIEF.md
# Boot ROM Overlay Memory Front End

This block sits between an 8-bit processor core and its memory. It decodes a 16-bit address space. A 16-byte window at 0x00F0–0x00FF is routed to a peripheral register port. The top 64 bytes (0xFFC0–0xFFFF) can be covered by a fixed boot ROM for reads, and everything else goes to a synchronous byte-wide RAM. The core presents one access per cycle. The access is an absolute address, a direct-page offset, a stack push or a stack pop. The block forms the effective address and holds the stack pointer and the ROM overlay flag.

Reads return one cycle after the request, whichever source serves them. Writes always reach RAM, including writes into the I/O window and writes beneath the enabled ROM. Code can therefore store data under the boot ROM and see it once the ROM is switched off. Bit 7 of a write to 0x00F1 switches the overlay on or off from the next access onward.

The RAM holds 2^RAM_AW bytes and repeats every 2^RAM_AW bytes of the address space. With RAM_AW = 16 it covers the whole map.

Top module: `boot_overlay_mem`

## Requirements
- R1: While rst_n is low, rom_on is 1, sp is SP_INIT (default 0xFF) and rd_valid is 0.
- R2: A read accepted at a clock edge raises rd_valid with its data for exactly the following cycle. A write or an idle cycle produces no rd_valid. Back-to-back reads return in issue order.
- R3: A read whose effective address lies in 0x00F0–0x00FF pulses io_rd_en with io_addr equal to the low 4 address bits. It returns the io_rdata value presented in the request cycle. No other address raises io_rd_en or io_wr_en.
- R4: A write in 0x00F0–0x00FF pulses io_wr_en with io_addr and io_wdata. It also stores the byte in RAM, where it can be read at an alias of that address (for example 0x10F0 with RAM_AW = 12).
- R5: While rom_on is 1, reads in 0xFFC0–0xFFFF return ROM byte i = (29*i + 195) mod 256, where i is the low 6 address bits.
- R6: Writes in 0xFFC0–0xFFFF always update RAM. After rom_on clears, reads there return the last bytes written, including those written while the ROM was on.
- R7: A write to 0x00F1 sets rom_on to bit 7 of the data, and the new value applies to the next access. No other access changes rom_on.
- R8: Push (req_kind = 2) writes req_data at 0x0100 | sp and then decrements sp by one.
- R9: Pop (req_kind = 3) increments sp first and then reads 0x0100 | sp.
- R10: Direct-page access (req_kind = 1) uses address {dp_page, req_addr[7:0]}, which is page 0 or page 1. Absolute access (req_kind = 0) uses req_addr unchanged.
- R11: Any other address, such as 0x00EF, 0x0100 or 0xFFBF, reads back the last byte written to it, modulo the RAM mirroring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_kind | input | 2 | 0 absolute, 1 direct page, 2 push, 3 pop |
| req_write | input | 1 | Write for absolute or direct-page access |
| req_addr | input | 16 | Absolute address, or offset in low byte |
| req_data | input | 8 | Write data |
| dp_page | input | 1 | Direct-page select (high byte 0 or 1) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| rom_on | output | 1 | Boot ROM overlay enabled |
| sp | output | 8 | Stack pointer |
| io_rd_en | output | 1 | Peripheral register read strobe |
| io_wr_en | output | 1 | Peripheral register write strobe |
| io_addr | output | 4 | Peripheral register index |
| io_wdata | output | 8 | Peripheral write data |
| io_rdata | input | 8 | Peripheral read data, valid in request cycle |

## Verification
The bench targets the window edges, 0x00EF against 0x00F0 and 0x00FF against 0x0100. A decoder that is off by one there would return peripheral data from RAM, or RAM data from the peripheral. It reads 0xFFBF and 0xFFC0 while the overlay is toggled on and off. A design that dropped writes under the ROM would return stale bytes after the ROM is switched off, and one that applied the control write late would return ROM data on the very next read. It reads I/O writes back through a RAM alias to catch a missing mirror. It pushes and pops to catch pre- and post-adjust swaps of the stack pointer.

// File: rtl/bom_pkg.sv
package bom_pkg;

   typedef enum logic [1:0] {
      ACC_ABS  = 2'd0,
      ACC_DP   = 2'd1,
      ACC_PUSH = 2'd2,
      ACC_POP  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      SRC_RAM = 2'd0,
      SRC_ROM = 2'd1,
      SRC_IO  = 2'd2
   } rd_src_e;

   localparam logic [15:0] CTRL_ADDR   = 16'h00F1;
   localparam int          ROM_EN_BIT  = 7;
   localparam logic [7:0]  STACK_PAGE  = 8'h01;

   // Fixed boot image: byte i = 29*i + 195 (mod 256)
   function automatic logic [7:0] boot_rom_byte(input logic [5:0] idx);
      logic [7:0] t;
      t = {2'b00, idx};
      return (t * 8'd29) + 8'd195;
   endfunction

endpackage

// File: rtl/bom_agen.sv
module bom_agen
   import bom_pkg::*;
#(
   parameter int         ADDR_W  = 16,
   parameter int         SP_W    = 8,
   parameter logic [7:0] SP_INIT = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              dp_page,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              eff_write,
   output logic [SP_W-1:0]   sp
);
   localparam int DP_PAD = ADDR_W - 9;

   acc_kind_e          kind;
   logic [SP_W-1:0]    sp_q;
   logic [SP_W-1:0]    sp_up;
   logic [SP_W-1:0]    sp_dn;

   assign kind  = acc_kind_e'(req_kind);
   assign sp_up = sp_q + 1'b1;
   assign sp_dn = sp_q - 1'b1;
   assign sp    = sp_q;

   always_comb begin
      eff_addr  = req_addr;
      eff_write = req_write;
      unique case (kind)
         ACC_ABS: begin
            eff_addr  = req_addr;
            eff_write = req_write;
         end
         ACC_DP: begin
            eff_addr  = {{DP_PAD{1'b0}}, dp_page, req_addr[7:0]};
            eff_write = req_write;
         end
         ACC_PUSH: begin
            eff_addr  = {STACK_PAGE, sp_q};
            eff_write = 1'b1;
         end
         ACC_POP: begin
            eff_addr  = {STACK_PAGE, sp_up};
            eff_write = 1'b0;
         end
         default: begin
            eff_addr  = req_addr;
            eff_write = req_write;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= SP_INIT;
      end else if (req_valid) begin
         if (kind == ACC_PUSH) begin
            sp_q <= sp_dn;
         end else if (kind == ACC_POP) begin
            sp_q <= sp_up;
         end
      end
   end

endmodule

// File: rtl/bom_decode.sv
module bom_decode
   import bom_pkg::*;
#(
   parameter int                ADDR_W  = 16,
   parameter int                IO_AW   = 4,
   parameter int                ROM_AW  = 6,
   parameter logic [ADDR_W-1:0] IO_BASE = 16'h00F0
) (
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic              eff_write,
   input  logic              rom_on,
   output rd_src_e           src,
   output logic              io_hit,
   output logic              ctrl_wr
);
   localparam logic [ADDR_W-IO_AW-1:0] IO_TAG = IO_BASE[ADDR_W-1:IO_AW];

   logic rom_zone;

   assign io_hit   = (eff_addr[ADDR_W-1:IO_AW] == IO_TAG);
   assign rom_zone = &eff_addr[ADDR_W-1:ROM_AW];
   assign ctrl_wr  = req_valid && eff_write && (eff_addr == CTRL_ADDR);

   always_comb begin
      if (io_hit) begin
         src = SRC_IO;
      end else if (rom_zone && rom_on) begin
         src = SRC_ROM;
      end else begin
         src = SRC_RAM;
      end
   end

endmodule

// File: rtl/bom_ram.sv
module bom_ram #(
   parameter int AW     = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) begin
            mem[addr] <= wdata;
         end else begin
            rdata <= mem[addr];
         end
      end
   end

endmodule

// File: rtl/bom_rom.sv
module bom_rom
   import bom_pkg::*;
#(
   parameter int ROM_AW = 6
) (
   input  logic              clk,
   input  logic              en,
   input  logic [ROM_AW-1:0] idx,
   output logic [7:0]        rdata
);
   localparam int DEPTH = 1 << ROM_AW;

   logic [7:0] image [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_image
      assign image[gi] = boot_rom_byte(6'(gi));
   end

   always_ff @(posedge clk) begin
      if (en) begin
         rdata <= image[idx];
      end
   end

endmodule

// File: rtl/boot_overlay_mem.sv
module boot_overlay_mem
   import bom_pkg::*;
#(
   parameter int         ADDR_W  = 16,
   parameter int         DATA_W  = 8,
   parameter int         RAM_AW  = 12,
   parameter int         ROM_AW  = 6,
   parameter int         IO_AW   = 4,
   parameter int         SP_W    = 8,
   parameter logic [7:0] SP_INIT = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic              req_write,
   input  logic [15:0]       req_addr,
   input  logic [7:0]        req_data,
   input  logic              dp_page,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              rom_on,
   output logic [7:0]        sp,
   output logic              io_rd_en,
   output logic              io_wr_en,
   output logic [3:0]        io_addr,
   output logic [7:0]        io_wdata,
   input  logic [7:0]        io_rdata
);
   localparam int RAM_BYTES = 1 << RAM_AW;
   localparam int ROM_BYTES = 1 << ROM_AW;

   if (ADDR_W != 16 || DATA_W != 8 || SP_W != 8) begin : g_bad_width
      $error("boot_overlay_mem: fixed 16-bit address, 8-bit data and stack pointer");
   end
   if (RAM_AW < 10 || RAM_AW > ADDR_W) begin : g_bad_ram
      $error("boot_overlay_mem: RAM_AW must be 10..16");
   end
   if (ROM_AW != 6 || IO_AW != 4) begin : g_bad_window
      $error("boot_overlay_mem: ROM window 64 bytes, I/O window 16 bytes");
   end
   if (RAM_BYTES < 4 * ROM_BYTES) begin : g_bad_ratio
      $error("boot_overlay_mem: RAM too small for overlay");
   end

   logic [ADDR_W-1:0] eff_addr;
   logic              eff_write;
   rd_src_e           src;
   rd_src_e           src_q;
   logic              io_hit;
   logic              ctrl_wr;
   logic              rom_on_q;
   logic              rd_valid_q;
   logic [DATA_W-1:0] io_q;
   logic [DATA_W-1:0] ram_q;
   logic [DATA_W-1:0] rom_q;
   logic              is_read;
   logic              is_write;

   bom_agen #(
      .ADDR_W  (ADDR_W),
      .SP_W    (SP_W),
      .SP_INIT (SP_INIT)
   ) u_agen (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .req_write (req_write),
      .req_addr  (req_addr),
      .dp_page   (dp_page),
      .eff_addr  (eff_addr),
      .eff_write (eff_write),
      .sp        (sp)
   );

   bom_decode #(
      .ADDR_W (ADDR_W),
      .IO_AW  (IO_AW),
      .ROM_AW (ROM_AW)
   ) u_decode (
      .req_valid (req_valid),
      .eff_addr  (eff_addr),
      .eff_write (eff_write),
      .rom_on    (rom_on_q),
      .src       (src),
      .io_hit    (io_hit),
      .ctrl_wr   (ctrl_wr)
   );

   assign is_read  = req_valid && !eff_write;
   assign is_write = req_valid &&  eff_write;

   bom_ram #(
      .AW     (RAM_AW),
      .DATA_W (DATA_W)
   ) u_ram (
      .clk   (clk),
      .en    (req_valid),
      .we    (eff_write),
      .addr  (eff_addr[RAM_AW-1:0]),
      .wdata (req_data),
      .rdata (ram_q)
   );

   bom_rom #(
      .ROM_AW (ROM_AW)
   ) u_rom (
      .clk   (clk),
      .en    (is_read),
      .idx   (eff_addr[ROM_AW-1:0]),
      .rdata (rom_q)
   );

   assign io_rd_en = is_read  && io_hit;
   assign io_wr_en = is_write && io_hit;
   assign io_addr  = eff_addr[IO_AW-1:0];
   assign io_wdata = req_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rom_on_q   <= 1'b1;
         rd_valid_q <= 1'b0;
         src_q      <= SRC_RAM;
         io_q       <= '0;
      end else begin
         rd_valid_q <= is_read;
         if (is_read) begin
            src_q <= src;
            io_q  <= io_rdata;
         end
         if (ctrl_wr) begin
            rom_on_q <= req_data[ROM_EN_BIT];
         end
      end
   end

   always_comb begin
      unique case (src_q)
         SRC_IO:  rd_data = io_q;
         SRC_ROM: rd_data = rom_q;
         default: rd_data = ram_q;
      endcase
   end

   assign rd_valid = rd_valid_q;
   assign rom_on   = rom_on_q;

endmodule

// File: rtl/bom_checker.sv
module bom_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [1:0]  req_kind,
   input logic        req_write,
   input logic [15:0] req_addr,
   input logic [7:0]  req_data,
   input logic        rd_valid,
   input logic        rom_on,
   input logic [7:0]  sp,
   input logic        io_rd_en,
   input logic        io_wr_en,
   input logic [3:0]  io_addr
);
   logic wants_read;
   logic abs_acc;
   logic ctrl_write;
   logic in_window;

   assign wants_read = req_valid && (req_kind == 2'd3 || (req_kind != 2'd2 && !req_write));
   assign abs_acc    = req_valid && (req_kind == 2'd0);
   assign ctrl_write = abs_acc && req_write && (req_addr == 16'h00F1);
   assign in_window  = (req_addr[15:4] == 12'h00F);

   AST_RESET_ROM_ON: assert property (@(posedge clk)
      !rst_n |=> rom_on);                                                        // R1

   AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      wants_read |=> rd_valid);                                                  // R2

   AST_NO_STRAY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !wants_read |=> !rd_valid);                                                // R2

   AST_IO_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (abs_acc && !req_write && in_window) |-> (io_rd_en && io_addr == req_addr[3:0])); // R3

   AST_IO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (abs_acc && !in_window) |-> (!io_rd_en && !io_wr_en));                     // R3

   AST_IO_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (abs_acc && req_write && in_window) |-> (io_wr_en && io_addr == req_addr[3:0])); // R4

   AST_CTRL_SETS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_write |=> (rom_on == $past(req_data[7])));                            // R7

   AST_ROM_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || req_kind != 2'd0 || !req_write || req_addr[15:4] != 12'h00F) |=> $stable(rom_on)); // R7

   AST_PUSH_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd2) |=> (sp == $past(sp) - 8'd1));             // R8

   AST_POP_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd3) |=> (sp == $past(sp) + 8'd1));             // R9

endmodule

bind boot_overlay_mem bom_checker u_bom_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_kind  (req_kind),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_data  (req_data),
   .rd_valid  (rd_valid),
   .rom_on    (rom_on),
   .sp        (sp),
   .io_rd_en  (io_rd_en),
   .io_wr_en  (io_wr_en),
   .io_addr   (io_addr)
);

// File: tb/boot_overlay_mem_bench.sv
module boot_overlay_mem_bench;
   localparam int CYC    = 20;
   localparam int RAM_AW = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_data = '0;
   logic        dp_page = 1'b0;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic        rom_on;
   logic [7:0]  sp;
   logic        io_rd_en;
   logic        io_wr_en;
   logic [3:0]  io_addr;
   logic [7:0]  io_wdata;
   logic [7:0]  io_rdata;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CYC/2) clk = ~clk;

   boot_overlay_mem u_boot_overlay_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_data  (req_data),
      .dp_page   (dp_page),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .rom_on    (rom_on),
      .sp        (sp),
      .io_rd_en  (io_rd_en),
      .io_wr_en  (io_wr_en),
      .io_addr   (io_addr),
      .io_wdata  (io_wdata),
      .io_rdata  (io_rdata)
   );

   // Peripheral stand-in: returns stored value XOR 0xA5
   logic [7:0] per_q [16];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) per_q[i] <= 8'h00;
      end else if (io_wr_en) begin
         per_q[io_addr] <= io_wdata;
      end
   end
   assign io_rdata = per_q[io_addr] ^ 8'hA5;

   // Reference model
   logic [7:0] ram_m [1 << RAM_AW];
   logic [7:0] io_m  [16];
   logic       rom_m = 1'b1;
   logic [7:0] sp_m  = 8'hFF;
   logic       dp_m  = 1'b0;

   // Scoreboard
   logic [7:0] exp_q [$];
   string      tag_q [$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] rom_ref(input logic [5:0] i);
      int v;
      v = (29 * int'(i) + 195) % 256;
      return v[7:0];
   endfunction

   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected rd_valid", {8'h00, rd_data}, 16'h0000);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rd_data === e, t, "read data", {8'h00, rd_data}, {8'h00, e});
         end
      end
   end

   task automatic acc(input logic [1:0] k, input logic [15:0] a, input bit w,
                      input logic [7:0] d, input string tag);
      logic [15:0] ea;
      bit          isw;
      logic [7:0]  e;
      isw = (k == 2'd2) || (k != 2'd3 && w);
      case (k)
         2'd0: ea = a;
         2'd1: ea = {7'b0, dp_m, a[7:0]};
         2'd2: begin ea = {8'h01, sp_m}; sp_m = sp_m - 8'd1; end
         default: begin sp_m = sp_m + 8'd1; ea = {8'h01, sp_m}; end
      endcase
      if (isw) begin
         ram_m[ea[RAM_AW-1:0]] = d;
         if (ea[15:4] == 12'h00F) io_m[ea[3:0]] = d;
         if (ea == 16'h00F1) rom_m = d[7];
      end else begin
         if (ea[15:4] == 12'h00F)            e = io_m[ea[3:0]] ^ 8'hA5;
         else if (rom_m && ea >= 16'hFFC0)   e = rom_ref(ea[5:0]);
         else                                e = ram_m[ea[RAM_AW-1:0]];
         exp_q.push_back(e);
         tag_q.push_back(tag);
      end
      @(negedge clk);
      req_valid = 1'b1;
      req_kind  = k;
      req_addr  = a;
      req_write = w;
      req_data  = d;
      dp_page   = dp_m;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) io_m[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(rom_on === 1'b1, "R1", "rom_on in reset", {15'b0, rom_on}, 16'h0001);
      check(sp === 8'hFF, "R1", "sp in reset", {8'h00, sp}, 16'h00FF);
      check(rd_valid === 1'b0, "R1", "rd_valid in reset", {15'b0, rd_valid}, 16'h0000);
      rst_n = 1'b1;
      idle(1);

      // R11 plain RAM around the window and overlay edges
      acc(2'd0, 16'h00EF, 1, 8'h11, "R11");
      acc(2'd0, 16'h0100, 1, 8'h22, "R11");
      acc(2'd0, 16'hFFBF, 1, 8'h33, "R11");
      acc(2'd0, 16'h0234, 1, 8'h44, "R11");
      acc(2'd0, 16'h00EF, 0, 8'h00, "R11");
      acc(2'd0, 16'h0100, 0, 8'h00, "R11");
      acc(2'd0, 16'hFFBF, 0, 8'h00, "R11");
      acc(2'd0, 16'h0234, 0, 8'h00, "R2");
      idle(1);

      // R5 ROM overlay reads
      acc(2'd0, 16'hFFC0, 0, 8'h00, "R5");
      acc(2'd0, 16'hFFFF, 0, 8'h00, "R5");
      acc(2'd0, 16'hFFE5, 0, 8'h00, "R5");
      // R6 writes beneath the ROM
      acc(2'd0, 16'hFFC0, 1, 8'h5A, "R6");
      acc(2'd0, 16'hFFFF, 1, 8'h6B, "R6");
      acc(2'd0, 16'hFFC0, 0, 8'h00, "R6");
      idle(2);

      // R3 / R4 I/O window
      acc(2'd0, 16'h00F0, 1, 8'h3C, "R4");
      acc(2'd0, 16'h00FF, 1, 8'h7E, "R4");
      acc(2'd0, 16'h00F0, 0, 8'h00, "R3");
      acc(2'd0, 16'h00FF, 0, 8'h00, "R3");
      acc(2'd0, 16'h10F0, 0, 8'h00, "R4");
      acc(2'd0, 16'h10FF, 0, 8'h00, "R4");
      idle(2);
      check(per_q[0] === 8'h3C, "R4", "peripheral reg 0", {8'h00, per_q[0]}, 16'h003C);
      check(per_q[15] === 8'h7E, "R4", "peripheral reg 15", {8'h00, per_q[15]}, 16'h007E);

      // R7 control register toggles
      acc(2'd0, 16'h00F1, 1, 8'h00, "R7");
      acc(2'd0, 16'hFFC0, 0, 8'h00, "R7");
      acc(2'd0, 16'hFFFF, 0, 8'h00, "R6");
      acc(2'd0, 16'h10F1, 0, 8'h00, "R4");
      idle(2);
      check(rom_on === 1'b0, "R7", "rom_on cleared", {15'b0, rom_on}, 16'h0000);
      acc(2'd0, 16'h00F1, 1, 8'h80, "R7");
      acc(2'd0, 16'hFFC0, 0, 8'h00, "R7");
      acc(2'd0, 16'h00F1, 1, 8'h7F, "R7");
      acc(2'd0, 16'hFFFF, 0, 8'h00, "R7");
      acc(2'd0, 16'hFFBF, 0, 8'h00, "R11");
      acc(2'd0, 16'h00F1, 1, 8'h80, "R7");
      acc(2'd0, 16'hFFFF, 0, 8'h00, "R7");
      idle(2);

      // R8 / R9 stack
      acc(2'd2, 16'h0000, 0, 8'hA1, "R8");
      acc(2'd2, 16'h0000, 0, 8'hB2, "R8");
      acc(2'd2, 16'h0000, 0, 8'hC3, "R8");
      idle(2);
      check(sp === 8'hFC, "R8", "sp after pushes", {8'h00, sp}, 16'h00FC);
      acc(2'd0, 16'h01FF, 0, 8'h00, "R8");
      acc(2'd0, 16'h01FD, 0, 8'h00, "R8");
      acc(2'd3, 16'h0000, 0, 8'h00, "R9");
      acc(2'd3, 16'h0000, 0, 8'h00, "R9");
      acc(2'd3, 16'h0000, 0, 8'h00, "R9");
      idle(2);
      check(sp === 8'hFF, "R9", "sp after pops", {8'h00, sp}, 16'h00FF);

      // R10 direct page
      dp_m = 1'b1;
      acc(2'd1, 16'hAB23, 1, 8'h9D, "R10");
      dp_m = 1'b0;
      acc(2'd1, 16'h5540, 1, 8'hE1, "R10");
      acc(2'd0, 16'h0123, 0, 8'h00, "R10");
      acc(2'd0, 16'h0040, 0, 8'h00, "R10");
      acc(2'd1, 16'h00F0, 0, 8'h00, "R10");
      dp_m = 1'b1;
      acc(2'd1, 16'h0000, 0, 8'h00, "R10");
      idle(4);

      check(exp_q.size() == 0, "R2", "reads outstanding", 16'(exp_q.size()), 16'h0000);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule